// File: doc/BRIEF.md
# Self-Repairing Majority Voter With Standby Spares

This block sits behind a group of replicated processing modules and a pool of idle standby copies. On every cycle where the sources present valid data it routes the outputs that currently hold a voting slot into a bitwise majority voter and registers the result. A result driven by a minority of faulty copies is therefore masked.

Each voting slot is also compared with the vote. A slot whose data keeps disagreeing is judged faulty. The module feeding it is retired for good, and the slot is handed to the next unused spare, so the group keeps enough healthy voters to mask later faults. Disagreement must persist over a set number of valid cycles before a spare is spent, so a single upset does not use one up. When a slot is judged faulty after the pool is exhausted, a sticky alarm tells the system that masking can no longer be restored. Voting carries on with whatever set is left.

Top module: `nmr_spare_voter`

## Requirements
- R1: On a cycle with `valid_i` high, bit b of `voted_o` after the next clock edge is 1 exactly when more than half of the N slot values have bit b set. On a cycle with `valid_i` low, `voted_o` keeps its value.
- R2: After reset, slot k is fed by module k, `active_o` has bits 0..N-1 set and all others clear, `retired_o` is 0, `no_spare_o` is 0 and `voted_o` is 0.
- R3: A slot is judged faulty only when its value differs from the vote on PERSIST valid cycles in a row. A valid cycle on which it agrees restarts the run. A cycle with `valid_i` low neither extends nor restarts the run.
- R4: A faulty slot takes the lowest-numbered unused spare. Spare j is source N+j and bit N+j of `active_o`; module k is bit k. `active_o` and `retired_o` change at the clock edge that ends the decision cycle.
- R5: When several slots are judged faulty on the same cycle, only the lowest-numbered one is replaced then. Any other slot is replaced on the next valid cycle on which it still disagrees.
- R6: A source that has left the active set never returns to it, and `retired_o` rises by exactly one per replacement.
- R7: When a slot is judged faulty and no spare is left, `no_spare_o` rises and stays high until reset. The active set is left unchanged, and voting continues over the remaining slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Source data valid this cycle |
| mod_i | input | N*W | Primary module outputs, module k in bits k*W +: W |
| spare_i | input | M*W | Standby spare outputs, spare j in bits j*W +: W |
| voted_o | output | W | Registered majority result |
| active_o | output | N+M | One bit per source, set while that source feeds a slot |
| retired_o | output | clog2(M+1) | Number of modules retired so far |
| no_spare_o | output | 1 | Sticky alarm: a fault was found with no spare left |

## Verification
The embedded properties watch, on every cycle, the invariants of the repair logic. The vote and the disagreement runs freeze while data is invalid, the active set always holds N sources, a primary that has left never returns, the retirement count only steps up by one, and the alarm never clears on its own. Whether the vote is the right majority, which slot gets which spare, and when the run length is reached can only be shown by the bench scenarios. These include a sweep over every combination of three four-bit values, transient and interrupted disagreement runs, two slots failing together and exhaustion of the pool. The bench checks them against a model of the requirements.

// File: rtl/nmr_pkg.sv
package nmr_pkg;

    // Width of source and slot indices; N+M must stay below 2**IDX_W
    localparam int IDX_W = 8;

    // Widest voter column the majority function handles
    localparam int MAX_SLOTS = 32;

    typedef logic [IDX_W-1:0] idx_t;

    // Replacement request from the disagreement detector
    typedef struct packed {
        logic hit;
        idx_t slot;
    } retire_req_t;

    // True when more than half of the first n bits of col are set
    function automatic logic majority_bit(input logic [MAX_SLOTS-1:0] col, input int n);
        int ones;
        ones = 0;
        for (int i = 0; i < MAX_SLOTS; i++) begin
            if (i < n && col[i]) begin
                ones = ones + 1;
            end
        end
        return (ones * 2 > n);
    endfunction

endpackage

// File: rtl/nmr_switch.sv
module nmr_switch
    import nmr_pkg::*;
#(
    parameter int N = 3,
    parameter int M = 2,
    parameter int W = 8
) (
    input  logic [(N+M)*W-1:0] src_i,
    input  idx_t               sel_i [N],
    output logic [N*W-1:0]     slot_o
);
    localparam int T = N + M;

    // Each voting slot picks one source by index
    for (genvar g = 0; g < N; g++) begin : g_slot
        always_comb begin
            slot_o[g*W +: W] = '0;
            for (int s = 0; s < T; s++) begin
                if (sel_i[g] == idx_t'(s)) begin
                    slot_o[g*W +: W] = src_i[s*W +: W];
                end
            end
        end
    end

endmodule

// File: rtl/nmr_voter.sv
module nmr_voter
    import nmr_pkg::*;
#(
    parameter int N = 3,
    parameter int W = 8
) (
    input  logic [N*W-1:0] slot_i,
    output logic [W-1:0]   vote_o
);
    // Bit-sliced majority: gather one column per bit position
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [MAX_SLOTS-1:0] col;
        always_comb begin
            col = '0;
            for (int g = 0; g < N; g++) begin
                col[g] = slot_i[g*W + b];
            end
        end
        assign vote_o[b] = majority_bit(col, N);
    end

endmodule

// File: rtl/nmr_detector.sv
module nmr_detector
    import nmr_pkg::*;
#(
    parameter int N       = 3,
    parameter int W       = 8,
    parameter int PERSIST = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           valid_i,
    input  logic [N*W-1:0] slot_i,
    input  logic [W-1:0]   vote_i,
    input  logic           swap_i,
    output retire_req_t    req_o
);
    localparam int CW = $clog2(PERSIST + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(PERSIST - 1);

    logic [N-1:0]    differ;
    logic [N-1:0]    qualify;
    logic [N*CW-1:0] run_q;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign differ[g]  = (slot_i[g*W +: W] != vote_i);
        assign qualify[g] = valid_i && differ[g] && (run_q[g*CW +: CW] == RUN_MAX);
    end

    // Lowest qualifying slot wins: scan from the top down
    always_comb begin
        req_o = '0;
        for (int g = N - 1; g >= 0; g--) begin
            if (qualify[g]) begin
                req_o.hit  = 1'b1;
                req_o.slot = idx_t'(g);
            end
        end
    end

    // Runs of consecutive valid disagreements, saturating at PERSIST-1
    for (genvar g = 0; g < N; g++) begin : g_run
        always_ff @(posedge clk) begin
            if (rst) begin
                run_q[g*CW +: CW] <= '0;
            end else if (valid_i) begin
                if (!differ[g] || (swap_i && req_o.slot == idx_t'(g))) begin
                    run_q[g*CW +: CW] <= '0;
                end else if (run_q[g*CW +: CW] != RUN_MAX) begin
                    run_q[g*CW +: CW] <= run_q[g*CW +: CW] + CW'(1);
                end
            end
        end
    end

    // R3
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(run_q));

    // R3
    req_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> !req_o.hit);

endmodule

// File: rtl/nmr_spare_mgr.sv
module nmr_spare_mgr
    import nmr_pkg::*;
#(
    parameter int N = 3,
    parameter int M = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  retire_req_t       req_i,
    output idx_t              sel_o [N],
    output logic              swap_o,
    output logic [N+M-1:0]    active_o,
    output logic [$clog2(M+1)-1:0] retired_o,
    output logic              no_spare_o
);
    localparam int T   = N + M;
    localparam int SPW = $clog2(M + 1);

    idx_t           sel_q [N];
    logic [SPW-1:0] next_q;
    logic           alarm_q;
    logic           have_spare;

    assign have_spare = (next_q < SPW'(M));
    assign swap_o     = req_i.hit && have_spare;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < N; g++) begin
                sel_q[g] <= idx_t'(g);
            end
            next_q  <= '0;
            alarm_q <= 1'b0;
        end else if (swap_o) begin
            for (int g = 0; g < N; g++) begin
                if (req_i.slot == idx_t'(g)) begin
                    sel_q[g] <= idx_t'(N) + idx_t'(next_q);
                end
            end
            next_q <= next_q + SPW'(1);
        end else if (req_i.hit) begin
            alarm_q <= 1'b1;
        end
    end

    always_comb begin
        active_o = '0;
        for (int s = 0; s < T; s++) begin
            for (int g = 0; g < N; g++) begin
                if (sel_q[g] == idx_t'(s)) begin
                    active_o[s] = 1'b1;
                end
            end
        end
    end

    assign sel_o      = sel_q;
    assign retired_o  = next_q;
    assign no_spare_o = alarm_q;

    // R4
    active_size_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(active_o) == N);

    // R6
    retire_step_chk: assert property (@(posedge clk) disable iff (rst)
        (retired_o != $past(retired_o)) |-> (retired_o == $past(retired_o) + SPW'(1)));

    // R7
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        no_spare_o |=> no_spare_o);

    // R7
    alarm_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i.hit && !have_spare) |=> $stable(active_o));

    // R6
    for (genvar k = 0; k < N; k++) begin : g_gone
        no_return_chk: assert property (@(posedge clk) disable iff (rst)
            !active_o[k] |=> !active_o[k]);
    end

endmodule

// File: rtl/nmr_spare_voter.sv
module nmr_spare_voter
    import nmr_pkg::*;
#(
    parameter int N       = 3,
    parameter int M       = 2,
    parameter int W       = 8,
    parameter int PERSIST = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   valid_i,
    input  logic [N*W-1:0]         mod_i,
    input  logic [M*W-1:0]         spare_i,
    output logic [W-1:0]           voted_o,
    output logic [N+M-1:0]         active_o,
    output logic [$clog2(M+1)-1:0] retired_o,
    output logic                   no_spare_o
);
    localparam int T = N + M;

    logic [T*W-1:0] sources;
    logic [N*W-1:0] slots;
    logic [W-1:0]   vote;
    logic [W-1:0]   voted_q;
    idx_t           sel [N];
    retire_req_t    req;
    logic           swap;

    assign sources = {spare_i, mod_i};

    nmr_switch #(.N(N), .M(M), .W(W)) u_switch (
        .src_i  (sources),
        .sel_i  (sel),
        .slot_o (slots)
    );

    nmr_voter #(.N(N), .W(W)) u_voter (
        .slot_i (slots),
        .vote_o (vote)
    );

    nmr_detector #(.N(N), .W(W), .PERSIST(PERSIST)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .valid_i (valid_i),
        .slot_i  (slots),
        .vote_i  (vote),
        .swap_i  (swap),
        .req_o   (req)
    );

    nmr_spare_mgr #(.N(N), .M(M)) u_spares (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .sel_o      (sel),
        .swap_o     (swap),
        .active_o   (active_o),
        .retired_o  (retired_o),
        .no_spare_o (no_spare_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            voted_q <= '0;
        end else if (valid_i) begin
            voted_q <= vote;
        end
    end

    assign voted_o = voted_q;

    // R1
    vote_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(voted_o));

    // R4
    swap_changes_map_chk: assert property (@(posedge clk) disable iff (rst)
        swap |=> (active_o != $past(active_o)));

endmodule

// File: tb/tb_nmr_spare_voter.sv
module tb_nmr_spare_voter;

    localparam int N = 3;
    localparam int M = 2;
    localparam int W = 4;
    localparam int P = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           valid_i = 1'b0;
    logic [N*W-1:0] mod_i = '0;
    logic [M*W-1:0] spare_i = '0;
    logic [W-1:0]   voted_o;
    logic [N+M-1:0] active_o;
    logic [1:0]     retired_o;
    logic           no_spare_o;

    int checks = 0;
    int fails  = 0;

    // Requirement model state
    int         msel [N];
    int         mrun [N];
    int         mnext;
    bit         mfault;
    logic [W-1:0] mvote;
    logic [W-1:0] srcv [N+M];

    always #5 clk = ~clk;

    nmr_spare_voter #(.N(N), .M(M), .W(W), .PERSIST(P)) dut (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (valid_i),
        .mod_i      (mod_i),
        .spare_i    (spare_i),
        .voted_o    (voted_o),
        .active_o   (active_o),
        .retired_o  (retired_o),
        .no_spare_o (no_spare_o)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int g = 0; g < N; g++) begin
            msel[g] = g;
            mrun[g] = 0;
        end
        mnext  = 0;
        mfault = 1'b0;
        mvote  = '0;
    endtask

    task automatic model_step(bit v);
        logic [W-1:0] vals [N];
        logic [W-1:0] vote;
        bit           dis [N];
        int           low;
        bit           swap;
        if (!v) return;
        for (int g = 0; g < N; g++) vals[g] = srcv[msel[g]];
        for (int b = 0; b < W; b++) begin
            int ones;
            ones = 0;
            for (int g = 0; g < N; g++) if (vals[g][b]) ones++;
            vote[b] = (ones * 2 > N);
        end
        low = -1;
        for (int g = N - 1; g >= 0; g--) begin
            dis[g] = (vals[g] != vote);
            if (dis[g] && mrun[g] == P - 1) low = g;
        end
        swap = (low >= 0) && (mnext < M);
        for (int g = 0; g < N; g++) begin
            if (!dis[g] || (swap && g == low)) mrun[g] = 0;
            else if (mrun[g] < P - 1) mrun[g]++;
        end
        if (swap) begin
            msel[low] = N + mnext;
            mnext++;
        end else if (low >= 0) begin
            mfault = 1'b1;
        end
        mvote = vote;
    endtask

    task automatic compare(string tag);
        logic [N+M-1:0] map;
        map = '0;
        for (int g = 0; g < N; g++) map[msel[g]] = 1'b1;
        check(tag, "voted", int'(voted_o), int'(mvote));
        check(tag, "active", int'(active_o), int'(map));
        check(tag, "retired", int'(retired_o), mnext);
        check(tag, "no_spare", int'(no_spare_o), int'(mfault));
    endtask

    // Drive at the falling edge, check after the next rising edge
    task automatic step(bit v, int m0, int m1, int m2, int s0, int s1, string tag);
        srcv[0] = W'(m0); srcv[1] = W'(m1); srcv[2] = W'(m2);
        srcv[3] = W'(s0); srcv[4] = W'(s1);
        valid_i = v;
        mod_i   = {srcv[2], srcv[1], srcv[0]};
        spare_i = {srcv[4], srcv[3]};
        model_step(v);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        valid_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        compare("R2");
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();

        // R1: every combination of three 4-bit values, each followed by a
        // unanimous cycle so no run reaches the retirement length
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int c = 0; c < 16; c++) begin
                    step(1, a, b, c, 0, 0, "R1");
                    step(1, a, a, a, 0, 0, "R1");
                end
        check("R2", "no retirement during sweep", int'(retired_o), 0);

        // R1: invalid cycle holds the vote
        step(1, 6, 6, 6, 0, 0, "R1");
        step(0, 1, 2, 3, 0, 0, "R1");
        check("R1", "held vote", int'(voted_o), 6);

        // R3: a transient run is cleared by agreement
        step(1, 5, 5, 9, 5, 0, "R3");
        step(1, 5, 5, 5, 5, 0, "R3");
        step(1, 5, 5, 9, 5, 0, "R3");
        check("R3", "no early retirement", int'(retired_o), 0);
        // R3: an invalid cycle neither clears nor extends the run
        step(0, 5, 5, 5, 5, 0, "R3");
        check("R3", "still no retirement", int'(retired_o), 0);
        step(1, 5, 5, 9, 5, 0, "R4");
        // R4: slot 2 now fed by spare 0 (source 3)
        check("R4", "map after first swap", int'(active_o), 5'b01011);

        // R6: module 2 agreeing again does not bring it back
        step(1, 5, 5, 5, 5, 0, "R6");
        step(1, 5, 5, 5, 5, 0, "R6");
        check("R6", "module 2 stays out", int'(active_o[2]), 0);

        // R5: slots 0 and 1 disagree together; only slot 0 replaced
        step(1, 1, 2, 9, 0, 0, "R5");
        step(1, 1, 2, 9, 0, 0, "R5");
        check("R5", "map after paired fault", int'(active_o), 5'b11010);
        check("R6", "one retirement per cycle", int'(retired_o), 2);

        // R7: slot 1 still disagrees with no spare left
        step(1, 1, 2, 9, 0, 0, "R7");
        check("R7", "alarm raised", int'(no_spare_o), 1);
        step(1, 0, 7, 3, 7, 0, "R7");
        check("R7", "vote over remaining set", int'(voted_o), 7);
        step(1, 0, 0, 0, 0, 0, "R7");
        check("R7", "alarm sticky", int'(no_spare_o), 1);
        check("R7", "map frozen", int'(active_o), 5'b11010);

        // R2: reset restores the initial assignment
        do_reset();
        step(1, 3, 3, 12, 0, 0, "R1");
        check("R1", "vote after second reset", int'(voted_o), 3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule